// File: doc/BRIEF.md
# DDR Read Capture Rate-Conversion FIFO

This block carries double-data-rate read data from the strobe clock domain into the core clock domain. On every strobe cycle in which the write enable is high, the capture side presents two words, one taken on the rising strobe edge and one on the falling edge. The block stores the pair as a single entry. The strobe clock and the core clock are treated as fully unrelated, so the block has a separate clock and a separate reset for each side. Pointers cross between the domains as Gray code through two-flop synchronizers.

The `RATE` parameter fixes the output format. In full-rate mode each accepted read returns one entry on a bus two words wide. In half-rate mode the core clock runs at half the strobe rate, and each accepted read returns two consecutive entries on a bus four words wide. There is no bypass path in either mode. Both domain resets must be applied together before any traffic starts.

Top module: `ddr_rate_fifo`

## Requirements
- R1: When `wrst` is applied, `full` and `overflow` are cleared. When `rrst` is applied, `empty` is set and `rd_valid` and `underflow` are cleared.
- R2: Entries are returned in the order they were accepted. Each entry is `{fall word, rise word}`, with the rising-edge word in the low DW bits.
- R3: In half-rate mode `rd_data` is 4*DW bits wide. Bits [2*DW-1:0] hold the earlier entry and bits [4*DW-1:2*DW] hold the later entry.
- R4: In full-rate mode `rd_data` is 2*DW bits wide, and each accepted read returns exactly one entry.
- R5: In half-rate mode `empty` stays high while fewer than two entries are stored, and no data is returned. In full-rate mode one stored entry is enough to clear `empty`.
- R6: `full` goes high once DEPTH entries are held unread. A write while `full` is high stores nothing, and that data never appears at the output. `full` goes low again after reads free space.
- R7: A write attempt while `full` is high sets `overflow`. The flag then stays high until `wrst`.
- R8: A read attempt while `empty` is high returns nothing and does not move the read pointer. It sets `underflow`, which then stays high until `rrst`.
- R9: `rd_valid` is high for exactly the one core cycle that follows each accepted read. In that cycle `rd_data` holds the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Strobe-domain clock |
| wrst | input | 1 | Synchronous active-high reset, strobe domain |
| wr_en | input | 1 | Store the current word pair |
| wr_rise | input | DW | Word captured on the rising strobe edge |
| wr_fall | input | DW | Word captured on the falling strobe edge |
| full | output | 1 | No free entry is left |
| overflow | output | 1 | Sticky: a write was attempted while full |
| rclk | input | 1 | Core-domain clock |
| rrst | input | 1 | Synchronous active-high reset, core domain |
| rd_en | input | 1 | Request one read |
| rd_data | output | 2*DW (full rate) or 4*DW (half rate) | Registered read data |
| rd_valid | output | 1 | `rd_data` holds fresh data |
| empty | output | 1 | Too few entries are stored for one read |
| underflow | output | 1 | Sticky: a read was attempted while empty |

## Verification
Some properties are checked by assertions on every clock edge. These cover the pointer hold on a refused write or read, the stickiness of both error flags, occupancy never exceeding the depth as seen from either side, the one-cycle `rd_valid` response, and the reset values. Other behaviour only shows up in the bench scenarios. Two instances, one per mode, share the same write stream. These scenarios show word ordering and packing, the two-entry threshold in half-rate mode, and dropped writes never reaching the output. They also show that ordering is kept under random traffic on two unrelated clocks.

// File: rtl/ddr_rate_fifo_pkg.sv
package ddr_rate_fifo_pkg;
  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;
endpackage

// File: rtl/ddr_rate_fifo_sync.sv
module ddr_rate_fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ddr_rate_fifo_mem.sv
module ddr_rate_fifo_mem #(
  parameter int EW   = 16,
  parameter int AW   = 3,
  parameter int RD_N = 2
) (
  input  logic               wclk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [EW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [RD_N*EW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar k = 0; k < RD_N; k++) begin : g_rd
    assign rdata[k*EW +: EW] = mem[raddr + AW'(k)];
  end
endmodule

// File: rtl/ddr_rate_fifo_wctl.sv
module ddr_rate_fifo_wctl #(
  parameter int AW = 3,
  parameter int SH = 1,
  localparam int PW = AW + 1 - SH
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          overflow
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0]   wbin, wbin_nx, occ, rbin_w;
  logic [PW-1:0] rpair_bin;

  always_comb begin
    rpair_bin[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rpair_bin[i] = rpair_bin[i+1] ^ rgray_s[i];
  end

  if (SH == 1) begin : g_pair
    assign rbin_w = {rpair_bin, 1'b0};
  end else begin : g_single
    assign rbin_w = rpair_bin;
  end

  assign occ     = wbin - rbin_w;
  assign full    = (occ == DEPTH_V);
  assign we      = wr_en & ~full;
  assign waddr   = wbin[AW-1:0];
  assign wbin_nx = wbin + (AW+1)'(1);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin     <= '0;
      wgray    <= '0;
      overflow <= 1'b0;
    end else begin
      if (we) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  p_hold_when_full_r6: assert property (@(posedge wclk) disable iff (wrst)
    (wr_en && full) |=> (wbin == $past(wbin)));
  p_occ_bound_r6: assert property (@(posedge wclk) disable iff (wrst)
    occ <= DEPTH_V);
  p_ovf_sticky_r7: assert property (@(posedge wclk) disable iff (wrst)
    overflow |=> overflow);
endmodule

// File: rtl/ddr_rate_fifo_rctl.sv
module ddr_rate_fifo_rctl #(
  parameter int AW = 3,
  parameter int SH = 1,
  localparam int PW = AW + 1 - SH
) (
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  output logic          take,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          underflow
);
  localparam logic [AW:0] STEP_V  = (AW+1)'(1 << SH);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0]   rbin, rbin_nx, wbin_s, avail;
  logic [PW-1:0] pair_nx;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign avail   = wbin_s - rbin;
  assign empty   = (avail < STEP_V);
  assign take    = rd_en & ~empty;
  assign raddr   = rbin[AW-1:0];
  assign rbin_nx = rbin + STEP_V;
  assign pair_nx = rbin_nx[AW:SH];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin      <= '0;
      rgray     <= '0;
      underflow <= 1'b0;
    end else begin
      if (take) begin
        rbin  <= rbin_nx;
        rgray <= pair_nx ^ (pair_nx >> 1);
      end
      if (rd_en && empty) underflow <= 1'b1;
    end
  end

  p_hold_when_empty_r8: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && empty) |=> $stable(rbin));
  p_unf_sticky_r8: assert property (@(posedge rclk) disable iff (rrst)
    underflow |=> underflow);
  p_avail_bound_r5: assert property (@(posedge rclk) disable iff (rrst)
    avail <= DEPTH_V);
endmodule

// File: rtl/ddr_rate_fifo.sv
module ddr_rate_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter ddr_rate_fifo_pkg::rate_e RATE = ddr_rate_fifo_pkg::RATE_HALF,
  localparam int RD_N = (RATE == ddr_rate_fifo_pkg::RATE_HALF) ? 2 : 1,
  localparam int OW   = RD_N * 2 * DW
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_rise,
  input  logic [DW-1:0] wr_fall,
  output logic          full,
  output logic          overflow,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          rd_en,
  output logic [OW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          underflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int SH = (RD_N == 2) ? 1 : 0;
  localparam int PW = AW + 1 - SH;
  localparam int EW = 2 * DW;

  logic          we, take;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, wgray_s;
  logic [PW-1:0] rgray, rgray_s;
  logic [OW-1:0] mem_q;

  ddr_rate_fifo_wctl #(.AW(AW), .SH(SH)) u_wctl (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full(full), .overflow(overflow)
  );

  ddr_rate_fifo_sync #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  ddr_rate_fifo_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
  );

  ddr_rate_fifo_rctl #(.AW(AW), .SH(SH)) u_rctl (
    .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .wgray_s(wgray_s),
    .take(take), .raddr(raddr), .rgray(rgray), .empty(empty), .underflow(underflow)
  );

  ddr_rate_fifo_mem #(.EW(EW), .AW(AW), .RD_N(RD_N)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata({wr_fall, wr_rise}),
    .raddr(raddr), .rdata(mem_q)
  );

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= take;
      if (take) rd_data <= mem_q;
    end
  end

  p_wreset_r1: assert property (@(posedge wclk)
    wrst |=> (!full && !overflow));
  p_rreset_r1: assert property (@(posedge rclk)
    rrst |=> (empty && !rd_valid && !underflow));
  p_valid_after_read_r9: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && !empty) |=> rd_valid);
  p_no_valid_when_empty_r8: assert property (@(posedge rclk) disable iff (rrst)
    (rd_en && empty) |=> !rd_valid);
endmodule

// File: tb/ddr_rate_fifo_bench.sv
`timescale 1ns/1ps
module ddr_rate_fifo_bench;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_rise = '0, wr_fall = '0;

  logic        h_full, h_ovf, h_valid, h_empty, h_unf;
  logic [31:0] h_data;
  logic        f_full, f_ovf, f_valid, f_empty, f_unf;
  logic [15:0] f_data;

  int checks = 0, errors = 0, h_pops = 0, f_pops = 0;
  logic [15:0] hq[$], fq[$];
  logic [31:0] h_last = '0;
  logic [15:0] f_last = '0;

  always #4.0  rclk = ~rclk;
  always #2.05 wclk = ~wclk;

  ddr_rate_fifo #(.DW(DW), .DEPTH(DEPTH), .RATE(ddr_rate_fifo_pkg::RATE_HALF)) u_ddr_rate_fifo (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_rise(wr_rise), .wr_fall(wr_fall),
    .full(h_full), .overflow(h_ovf), .rclk(rclk), .rrst(rrst), .rd_en(rd_en),
    .rd_data(h_data), .rd_valid(h_valid), .empty(h_empty), .underflow(h_unf)
  );

  ddr_rate_fifo #(.DW(DW), .DEPTH(DEPTH), .RATE(ddr_rate_fifo_pkg::RATE_FULL)) u_ddr_rate_fifo_fr (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_rise(wr_rise), .wr_fall(wr_fall),
    .full(f_full), .overflow(f_ovf), .rclk(rclk), .rrst(rrst), .rd_en(rd_en),
    .rd_data(f_data), .rd_valid(f_valid), .empty(f_empty), .underflow(f_unf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_pair(input logic [15:0] early, input logic [15:0] late);
    return {late, early};
  endfunction

  task automatic wr_cycle(input bit en, input logic [DW-1:0] r, input logic [DW-1:0] f);
    @(negedge wclk);
    if (en && !h_full) hq.push_back({f, r});
    if (en && !f_full) fq.push_back({f, r});
    wr_en = en; wr_rise = r; wr_fall = f;
  endtask

  task automatic rd_cycle(input bit en);
    @(negedge rclk);
    rd_en = en;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  // R2 R3 R4: returned data compared with the bench queues
  always @(negedge rclk) begin
    if (!rrst && h_valid) begin
      h_pops++;
      h_last = h_data;
      if (hq.size() < 2) chk(1'b0, "R2 R3 half-rate data with nothing queued", 64'(h_data), 64'(0));
      else begin
        chk(h_data == pack_pair(hq[0], hq[1]), "R2 R3 half-rate order and packing",
            64'(h_data), 64'(pack_pair(hq[0], hq[1])));
        void'(hq.pop_front());
        void'(hq.pop_front());
      end
    end
    if (!rrst && f_valid) begin
      f_pops++;
      f_last = f_data;
      if (fq.size() < 1) chk(1'b0, "R2 R4 full-rate data with nothing queued", 64'(f_data), 64'(0));
      else begin
        chk(f_data == fq[0], "R2 R4 full-rate order", 64'(f_data), 64'(fq[0]));
        void'(fq.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge rclk);
    chk(1'b0, "watchdog", 64'(0), 64'(1));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_r(5);
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
    wait_r(1);
    // R1 reset values
    chk(!h_full && !f_full, "R1 full after reset", 64'({h_full, f_full}), 64'(0));
    chk(!h_ovf && !f_ovf, "R1 overflow after reset", 64'({h_ovf, f_ovf}), 64'(0));
    chk(h_empty && f_empty, "R1 empty after reset", 64'({h_empty, f_empty}), 64'(3));
    chk(!h_valid && !f_valid && !h_unf && !f_unf, "R1 valid/underflow after reset",
        64'({h_valid, f_valid, h_unf, f_unf}), 64'(0));

    // R8 read while empty
    rd_cycle(1); rd_cycle(0); wait_r(3);
    chk(h_unf && f_unf, "R8 underflow set", 64'({h_unf, f_unf}), 64'(3));
    chk(h_pops == 0 && f_pops == 0, "R8 no data on empty read", 64'(h_pops + f_pops), 64'(0));
    wait_r(4);
    chk(h_unf && f_unf, "R8 underflow sticky", 64'({h_unf, f_unf}), 64'(3));

    // R5 one entry: half-rate stays empty, full-rate does not
    wr_cycle(1, 8'h11, 8'h22); wr_cycle(0, 8'h00, 8'h00);
    wait_r(10);
    chk(h_empty == 1'b1, "R5 half-rate empty with one entry", 64'(h_empty), 64'(1));
    chk(f_empty == 1'b0, "R5 full-rate ready with one entry", 64'(f_empty), 64'(0));
    rd_cycle(1);
    @(negedge rclk); rd_en = 1'b0;
    chk(f_valid == 1'b1, "R9 valid one cycle after read", 64'(f_valid), 64'(1));
    wait_r(1);
    chk(f_valid == 1'b0, "R9 valid lasts one cycle", 64'(f_valid), 64'(0));
    wait_r(2);
    chk(f_last == 16'h2211, "R4 single entry, rise word low", 64'(f_last), 64'h2211);
    chk(h_pops == 0, "R5 half-rate returned nothing", 64'(h_pops), 64'(0));

    // R3 second entry completes a pair
    wr_cycle(1, 8'h33, 8'h44); wr_cycle(0, 8'h00, 8'h00);
    wait_r(10);
    chk(h_empty == 1'b0, "R5 half-rate ready with two entries", 64'(h_empty), 64'(0));
    rd_cycle(1); rd_cycle(0); wait_r(3);
    chk(h_last == 32'h44332211, "R3 earlier entry in low half", 64'(h_last), 64'h44332211);
    chk(f_last == 16'h4433, "R4 next entry", 64'(f_last), 64'h4433);

    // R6 R7 fill past depth with reader idle
    for (int i = 0; i < DEPTH + 3; i++) wr_cycle(1, 8'h50 + 8'(i), 8'hA0 + 8'(i));
    wr_cycle(0, 8'h00, 8'h00);
    @(negedge wclk);
    chk(h_full && f_full, "R6 full at depth", 64'({h_full, f_full}), 64'(3));
    chk(h_ovf && f_ovf, "R7 overflow on dropped write", 64'({h_ovf, f_ovf}), 64'(3));
    chk(hq.size() == DEPTH && fq.size() == DEPTH, "R6 accepted count", 64'(hq.size()), 64'(DEPTH));
    rd_cycle(1); wait_r(20); rd_cycle(0); wait_r(4);
    chk(hq.size() == 0 && fq.size() == 0, "R6 dropped writes never returned",
        64'(hq.size() + fq.size()), 64'(0));
    chk(h_pops == 1 + DEPTH / 2, "R6 half-rate pair count", 64'(h_pops), 64'(1 + DEPTH / 2));
    repeat (6) @(negedge wclk);
    chk(!h_full && !f_full, "R6 full clears after reads", 64'({h_full, f_full}), 64'(0));
    chk(h_ovf && f_ovf, "R7 overflow sticky", 64'({h_ovf, f_ovf}), 64'(3));

    // R2 random traffic on unrelated clocks
    fork
      for (int i = 0; i < 3000; i++)
        wr_cycle(($urandom % 2) == 0, 8'($urandom), 8'($urandom));
      for (int i = 0; i < 1500; i++)
        rd_cycle(($urandom % 2) == 0);
    join
    wr_cycle(0, 8'h00, 8'h00);
    wait_r(4);
    rd_cycle(1); wait_r(40); rd_cycle(0); wait_r(4);
    chk(hq.size() < 2, "R2 half-rate drained", 64'(hq.size()), 64'(0));
    chk(fq.size() == 0, "R2 full-rate drained", 64'(fq.size()), 64'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule